// File: doc/BRIEF.md
# Indirect Register Window Port

This block lets an 8-bit processor bus reach a 64-entry internal register file through a narrow window. A two-bit style input picks one of two bus styles. In the direct style, the select line chooses between the address pointer and the data window. In the multiplexed style, the shared bus carries the address while the latch-enable line is high. The bus strobes are active low and are sampled on the block clock. An access takes effect on the clock edge where its strobe is seen released after being seen active together with chip select.

Reads never go to the register file straight from the bus. They return a data-out latch. The latch is refilled from the register at the pointer after the pointer is loaded, after every data read and after every data write. Because data accesses leave the pointer alone, a processor can run back-to-back reads or writes against one register without resending the address. This suits a FIFO data port. On the inside, the block drives a plain register-file port: one address, one write strobe with write data, one read strobe, and a combinational read-data return.

Top module: `regwin_port`

## Requirements
- R1: After synchronous reset the pointer (seen on rf_addr) is 0, the data-in register (seen on rf_wdata) is 0, and neither rf_we nor rf_re is asserted.
- R2: With mode = 00 (direct style), a write with a0_ale = 1 loads the pointer from bus_din[5:0]. Bits 7:6 are discarded.
- R3: With mode = 00, a write with a0_ale = 0 gives exactly one rf_we pulse, with rf_addr equal to the pointer and rf_wdata equal to the written byte.
- R4: A read with a0_ale = 0 returns the data-out latch on bus_dout. After a pointer load, the latch holds the content of the register now addressed.
- R5: Every data read causes exactly one reload of the latch (one rf_re pulse), so the next read returns the register's current content.
- R6: After a data write, the latch holds the byte just written.
- R7: Data reads and data writes leave the pointer unchanged.
- R8: With mode = 01 (multiplexed style), the pointer follows bus_din[5:0] while a0_ale is high. A following WR strobe writes that register, and a following RD strobe returns its content.
- R9: bus_oe is asserted only while cs_n and rd_n are both low.
- R10: Read and write strobes given while cs_n is high cause no register-file write and no pointer change.
- R11: With mode = 10 or 11, no strobe writes the register file or changes the pointer.
- R12: In the direct style, a read with a0_ale = 1 leaves the pointer and the latch untouched and issues no rf_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Bus style: 00 direct, 01 multiplexed, 1x no access |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0_ale | input | 1 | Pointer/data select (direct) or address latch enable (multiplexed) |
| bus_din | input | 8 | Incoming side of the data bus |
| bus_dout | output | 8 | Outgoing side of the data bus (data-out latch) |
| bus_oe | output | 1 | Drive enable for the data bus |
| rf_addr | output | 6 | Register-file address (the pointer) |
| rf_wdata | output | 8 | Register-file write data (the data-in register) |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_re | output | 1 | Register-file read strobe, one cycle, marks a latch reload |
| rf_rdata | input | 8 | Register-file read data, combinational from rf_addr |

## Verification
The bench targets the reload ordering. It changes a register behind the block's back between two reads, so the first read must still show the stale latch and the second must show the new value. A design that reloads before the read instead of after it, or not at all, returns the wrong byte in one of the two. Right after a data write, the bench reads back to catch a reload that samples the register file before the write has landed, which would return the old content. The bench also sends pointer writes with the top bits set, strobes without chip select, reads with a0_ale = 1 and accesses in the reserved modes. A design that keeps the top bits, or acts on any of those other strobes, moves rf_addr or adds an rf_we or rf_re pulse. A long run of random bursts in both styles then checks that the pointer never drifts during data accesses.

// File: rtl/rw_pkg.sv
package rw_pkg;

    typedef enum logic [1:0] {
        BUS_DIRECT = 2'b00,
        BUS_MUXED  = 2'b01,
        BUS_OFF_A  = 2'b10,
        BUS_OFF_B  = 2'b11
    } bus_style_e;

    typedef struct packed {
        logic ptr_wr;
        logic data_wr;
        logic data_rd;
        logic ale_hi;
        logic ale_fall;
    } bus_evt_t;

    function automatic logic style_active(input bus_style_e s);
        return (s == BUS_DIRECT) || (s == BUS_MUXED);
    endfunction

endpackage

// File: rtl/rw_strobe.sv
module rw_strobe
    import rw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_style_e    style,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0_ale,
    input  logic [DW-1:0] bus_din,
    output bus_evt_t      evt,
    output logic [DW-1:0] held_din
);

    logic prev_cs_n, prev_rd_n, prev_wr_n, prev_a0;
    logic active, muxed, rd_end, wr_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cs_n <= 1'b1;
            prev_rd_n <= 1'b1;
            prev_wr_n <= 1'b1;
            prev_a0   <= 1'b0;
            held_din  <= '0;
        end else begin
            prev_cs_n <= cs_n;
            prev_rd_n <= rd_n;
            prev_wr_n <= wr_n;
            prev_a0   <= a0_ale;
            held_din  <= bus_din;
        end
    end

    always_comb begin
        active = style_active(style);
        muxed  = (style == BUS_MUXED);
        rd_end = active && !prev_rd_n && rd_n && !prev_cs_n;
        wr_end = active && !prev_wr_n && wr_n && !prev_cs_n;
        evt.ptr_wr   = wr_end && !muxed && prev_a0;
        evt.data_wr  = wr_end && (muxed || !prev_a0);
        evt.data_rd  = rd_end && (muxed || !prev_a0);
        evt.ale_hi   = muxed && a0_ale;
        evt.ale_fall = muxed && prev_a0 && !a0_ale;
    end

endmodule

// File: rtl/rw_ptr.sv
module rw_ptr
    import rw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [DW-1:0] held_din,
    input  logic [AW-1:0] live_addr,
    output logic [AW-1:0] ptr,
    output logic [DW-1:0] data_in,
    output logic          we_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            data_in <= '0;
            we_q    <= 1'b0;
        end else begin
            if (evt.ale_hi)
                ptr <= live_addr;
            else if (evt.ptr_wr)
                ptr <= held_din[AW-1:0];
            if (evt.data_wr)
                data_in <= held_din;
            we_q <= evt.data_wr;
        end
    end

endmodule

// File: rtl/rw_fetch.sv
module rw_fetch #(
    parameter int DW         = 8,
    parameter bit CLEAR_DOUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [DW-1:0] rf_rdata,
    output logic [DW-1:0] dout,
    output logic          pend
);

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= trig;
    end

    generate
        if (CLEAR_DOUT) begin : g_clr
            always_ff @(posedge clk) begin
                if (rst)       dout <= '0;
                else if (pend) dout <= rf_rdata;
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (pend) dout <= rf_rdata;
            end
        end
    endgenerate

endmodule

// File: rtl/regwin_port.sv
module regwin_port
    import rw_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int DW         = 8,
    parameter bit CLEAR_DOUT = 1'b1,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0_ale,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we,
    output logic          rf_re,
    input  logic [DW-1:0] rf_rdata
);

    bus_evt_t      evt;
    logic [DW-1:0] held_din;
    logic          we_q;
    logic          reload_trig;

    rw_strobe #(.DW(DW)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .style    (bus_style_e'(mode)),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .a0_ale   (a0_ale),
        .bus_din  (bus_din),
        .evt      (evt),
        .held_din (held_din)
    );

    rw_ptr #(.AW(AW), .DW(DW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .held_din  (held_din),
        .live_addr (bus_din[AW-1:0]),
        .ptr       (rf_addr),
        .data_in   (rf_wdata),
        .we_q      (we_q)
    );

    // A data write reloads one cycle later, once the write has landed.
    assign reload_trig = evt.ptr_wr || evt.data_rd || evt.ale_fall || we_q;

    rw_fetch #(.DW(DW), .CLEAR_DOUT(CLEAR_DOUT)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .trig     (reload_trig),
        .rf_rdata (rf_rdata),
        .dout     (bus_dout),
        .pend     (rf_re)
    );

    assign rf_we  = we_q;
    assign bus_oe = !cs_n && !rd_n;

endmodule

// File: rtl/regwin_port_chk.sv
module regwin_port_chk #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          cs_n,
    input logic          bus_oe,
    input logic [AW-1:0] rf_addr,
    input logic [DW-1:0] rf_wdata,
    input logic          rf_we,
    input logic          rf_re
);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (rf_addr == '0 && rf_wdata == '0 && !rf_we));

    p_single_write_r3: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    p_single_reload_r5: assert property (@(posedge clk) disable iff (rst)
        rf_re |=> !rf_re);

    p_burst_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $stable(rf_addr));

    p_oe_needs_select_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !bus_oe);

    p_off_mode_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (mode >= 2'b10 && $past(mode) >= 2'b10 && $past(mode, 2) >= 2'b10)
        |-> (!rf_we && !rf_re && $stable(rf_addr)));

endmodule

bind regwin_port regwin_port_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .cs_n     (cs_n),
    .bus_oe   (bus_oe),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_we    (rf_we),
    .rf_re    (rf_re)
);

// File: tb/sim_regwin_port.sv
module sim_regwin_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0_ale = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, rf_wdata, rf_rdata;
    logic       bus_oe, rf_we, rf_re;
    logic [5:0] rf_addr;

    always #10 clk = ~clk;

    regwin_port u0 (
        .clk(clk), .rst(rst), .mode(mode), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .a0_ale(a0_ale), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
    );

    // Bench register file with a side door for changing content.
    logic [7:0] mem [64];
    logic [7:0] shadow [64];
    logic       poke_en = 1'b0;
    logic [5:0] poke_addr = '0;
    logic [7:0] poke_val = '0;
    int         we_cnt = 0, re_cnt = 0;
    logic [5:0] last_waddr = '0;
    logic [7:0] last_wdata = '0;

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_val;
        else if (rf_we) mem[rf_addr] <= rf_wdata;
        if (rf_we) begin
            we_cnt     <= we_cnt + 1;
            last_waddr <= rf_addr;
            last_wdata <= rf_wdata;
        end
        if (rf_re) re_cnt <= re_cnt + 1;
    end
    assign rf_rdata = mem[rf_addr];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) ^ 8'h5C);
    endfunction

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk) a0_ale = a; bus_din = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk) cs_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d, output logic oe);
        @(negedge clk) a0_ale = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk) d = bus_dout; oe = bus_oe; cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic mux_addr(input logic [7:0] a);
        @(negedge clk) a0_ale = 1'b1; bus_din = a;
        @(negedge clk) a0_ale = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) a0_ale = 1'b0;
        @(negedge clk) mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic poke(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk) poke_en = 1'b1; poke_addr = a; poke_val = v;
        @(negedge clk) poke_en = 1'b0;
        shadow[a] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, exp_latch, x;
        logic       oe;
        logic [5:0] exp_ptr;
        int         snap_we, snap_re;
        int unsigned seed_dummy;

        for (int i = 0; i < 64; i++) begin
            mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 addr", rf_addr, 0);
        check("R1 wdata", rf_wdata, 0);
        check("R1 we", we_cnt, 0);
        check("R1 re", re_cnt, 0);

        // R2 pointer load, upper bits dropped
        bus_write(1'b1, 8'hE5);
        check("R2 ptr", rf_addr, 6'h25);

        // R4 read after pointer load, R9 drive during read
        bus_read(1'b0, d, oe);
        check("R4 data", d, shadow[6'h25]);
        check("R9 oe in read", oe, 1);

        // R3 data write
        snap_we = we_cnt;
        bus_write(1'b0, 8'h5A);
        shadow[6'h25] = 8'h5A;
        check("R3 one pulse", we_cnt - snap_we, 1);
        check("R3 addr", last_waddr, 6'h25);
        check("R3 data", last_wdata, 8'h5A);

        // R6 latch holds the written byte
        bus_read(1'b0, d, oe);
        check("R6 readback", d, 8'h5A);
        check("R7 ptr after burst", rf_addr, 6'h25);

        // R5 reload after each read
        poke(6'h25, 8'hC3);
        snap_re = re_cnt;
        bus_read(1'b0, d, oe);
        check("R5 stale first", d, 8'h5A);
        check("R5 one reload", re_cnt - snap_re, 1);
        bus_read(1'b0, d, oe);
        check("R5 fresh second", d, 8'hC3);

        // R10 strobes without select
        snap_we = we_cnt;
        @(negedge clk) a0_ale = 1'b1; bus_din = 8'h3F; wr_n = 1'b0;
        @(negedge clk) wr_n = 1'b1;
        @(negedge clk) a0_ale = 1'b0; bus_din = 8'hFF; wr_n = 1'b0;
        @(negedge clk) wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 no write", we_cnt - snap_we, 0);
        check("R10 ptr", rf_addr, 6'h25);

        // R9 no drive without both low
        @(negedge clk) rd_n = 1'b0;
        @(negedge clk) oe = bus_oe; rd_n = 1'b1;
        check("R9 cs high", oe, 0);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) oe = bus_oe; cs_n = 1'b1;
        check("R9 rd high", oe, 0);

        // R12 reserved read
        snap_re = re_cnt;
        bus_read(1'b1, d, oe);
        check("R12 no reload", re_cnt - snap_re, 0);
        check("R12 ptr", rf_addr, 6'h25);
        poke(6'h25, 8'h96);
        bus_read(1'b0, d, oe);
        check("R12 latch kept", d, 8'hC3);

        // R8 multiplexed style
        set_mode(2'b01);
        mux_addr(8'hCA);
        check("R8 addr latch", rf_addr, 6'h0A);
        bus_read(1'b0, d, oe);
        check("R8 read", d, shadow[6'h0A]);
        snap_we = we_cnt;
        bus_write(1'b0, 8'h77);
        shadow[6'h0A] = 8'h77;
        check("R8 write addr", last_waddr, 6'h0A);
        check("R8 write count", we_cnt - snap_we, 1);
        bus_read(1'b0, d, oe);
        check("R8 readback", d, 8'h77);

        // R11 off modes
        for (int m = 2; m < 4; m++) begin
            set_mode(2'(m));
            snap_we = we_cnt;
            snap_re = re_cnt;
            bus_write(1'b0, 8'h11);
            bus_write(1'b1, 8'h33);
            bus_read(1'b0, d, oe);
            check("R11 no write", we_cnt - snap_we, 0);
            check("R11 no reload", re_cnt - snap_re, 0);
            check("R11 ptr", rf_addr, 6'h0A);
        end

        // Random mix, fixed seed
        set_mode(2'b00);
        seed_dummy = $urandom(32'd2024);
        exp_ptr = 6'h0A;
        bus_write(1'b1, 8'h0A);
        exp_latch = shadow[exp_ptr];
        for (int i = 0; i < 300; i++) begin
            x = 8'($urandom);
            case ($urandom % 5)
                0: begin
                    bus_write(1'b1, x);
                    exp_ptr = x[5:0];
                    exp_latch = shadow[exp_ptr];
                    check("R2 rand ptr", rf_addr, exp_ptr);
                end
                1: begin
                    bus_write(1'b0, x);
                    shadow[exp_ptr] = x;
                    exp_latch = x;
                    check("R7 rand ptr", rf_addr, exp_ptr);
                end
                2: begin
                    bus_read(1'b0, d, oe);
                    check("R4 rand read", d, exp_latch);
                    exp_latch = shadow[exp_ptr];
                end
                3: begin
                    poke(exp_ptr, x);
                    bus_read(1'b0, d, oe);
                    check("R5 rand stale", d, exp_latch);
                    exp_latch = x;
                end
                default: begin
                    set_mode(2'b01);
                    mux_addr(x);
                    exp_ptr = x[5:0];
                    exp_latch = shadow[exp_ptr];
                    if (x[7]) begin
                        bus_write(1'b0, ~x);
                        shadow[exp_ptr] = ~x;
                        exp_latch = ~x;
                    end
                    bus_read(1'b0, d, oe);
                    check("R8 rand read", d, exp_latch);
                    exp_latch = shadow[exp_ptr];
                    set_mode(2'b00);
                end
            endcase
        end

        for (int i = 0; i < 64; i++)
            check("R3 final memory", mem[i], shadow[i]);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule